// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered clock runs close enough to its nominal rate for a clock-recovery loop to switch from frequency acquisition to phase tracking. It counts recovered-clock events during a gate window whose length is a fixed number of reference-clock events. At the close of each window it compares the count with the count that is nominal for the selected reference frequency and finds the absolute error. It then updates a loss-of-lock flag using two thresholds. Lock is declared when the error is within 500 ppm of the nominal count, and it is dropped only when the error grows beyond 1000 ppm. Errors between the two thresholds leave the flag as it was.

Both clocks arrive as single-cycle strobes in the block's own clock domain. Upstream logic samples and edge-detects them, and it prescales the recovered clock so that the expected ratio to the slowest reference is `RATIO_00`. A 2-bit select picks the reference rate, from 19.44 MHz up to 155.52 MHz in steps of two. A faster reference means fewer recovered events per reference event, so the nominal count halves for each step. A loop-select output follows the loss-of-lock flag and steers the loop to the frequency path while lock is absent.

Top module: `freq_lock_monitor`

## Requirements
- R1: Out of reset, `lol_o` is 1, `freq_loop_o` is 1 and `meas_valid_o` is 0.
- R2: A window closes on the `WIN_REFS`-th `ref_tick_i` strobe since the last close, restart or reset. The recovered strobes counted are the ones from the cycle after the previous close up to and including the closing cycle. `meas_valid_o` pulses high for exactly one cycle, in the cycle after the closing cycle, and is low otherwise.
- R3: The nominal count is `(RATIO_00 >> sel) * WIN_REFS`. The `ref_sel_i` encodings are 2'b00 = 19.44 MHz, 2'b01 = 38.88 MHz, 2'b10 = 77.76 MHz and 2'b11 = 155.52 MHz.
- R4: While `lol_o` is 1, a window whose absolute error is at most floor(nominal·LOCK_PPM/10^6) (LOCK_PPM = 500) clears `lol_o` in the same cycle that `meas_valid_o` rises.
- R5: While `lol_o` is 0, a window whose absolute error exceeds floor(nominal·LOSE_PPM/10^6) (LOSE_PPM = 1000) sets `lol_o` in the same cycle that `meas_valid_o` rises. An error exactly equal to that threshold keeps lock.
- R6: An error above the lock threshold but not above the loss threshold leaves `lol_o` unchanged. `lol_o` never changes in a cycle without `meas_valid_o` unless a select change or reset occurs.
- R7: `freq_loop_o` equals `lol_o` at all times: 1 selects the frequency loop and 0 the phase loop.
- R8: A change on `ref_sel_i` discards the window in progress and starts a new one. `lol_o` goes to 1 in the next cycle, and the partial window produces no `meas_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are synchronous to it |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference-clock event |
| rec_tick_i | input | 1 | One-cycle strobe per prescaled recovered-clock event |
| ref_sel_i | input | 2 | Reference frequency select |
| lol_o | output | 1 | Loss-of-lock flag, 1 = not locked |
| freq_loop_o | output | 1 | Loop select, 1 = frequency loop, 0 = phase loop |
| meas_valid_o | output | 1 | One-cycle pulse when a window's result has been applied |

## Verification
On every cycle, the embedded properties check the following: the flag reacts at a window close exactly as the two thresholds dictate, it holds still between closes, a select change forces it high and suppresses the strobe, and the valid pulse never lasts two cycles. Only the directed scenarios can show that the counts fed to that decision are correct. This covers the window aligning to the right reference strobe, the nominal count scaling with the select, and a discarded partial window not leaking into the next result. They also probe the thresholds at their exact boundary values and trace the full acquire, hold, lose and reacquire cycle.

// File: rtl/fld_pkg.sv
// Package: shared types and constant helpers for the frequency lock detector.
// Assumes all arguments are elaboration-time constants; the functions only
// build threshold tables and are never evaluated on live data.
package fld_pkg;

    // Encoding of the loop-select output.
    typedef enum logic {
        LOOP_PHASE = 1'b0,
        LOOP_FREQ  = 1'b1
    } loop_sel_e;

    // Nominal recovered-event count for one window at a given reference select.
    function automatic longint unsigned nominal_count(input int unsigned ratio0,
                                                      input int unsigned win,
                                                      input int unsigned sel);
        return longint'(ratio0 >> sel) * longint'(win);
    endfunction

    // Integer threshold: floor(count * ppm / 1e6).
    function automatic longint unsigned ppm_limit(input longint unsigned cnt,
                                                  input int unsigned ppm);
        return (cnt * longint'(ppm)) / 64'd1000000;
    endfunction

endpackage

// File: rtl/fld_gate.sv
// Module: fld_gate
// Counts reference strobes to form a gate window of WIN_REFS events and
// counts recovered strobes inside it. On the closing reference strobe it
// latches the count and raises done_o for one cycle. The recovered counter
// saturates instead of wrapping. Assumes WIN_REFS >= 2.
module fld_gate #(
    parameter int unsigned WIN_REFS = 1024,
    parameter int unsigned CNT_W    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             ref_tick_i,
    input  logic             rec_tick_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned RW = $clog2(WIN_REFS);
    localparam logic [RW-1:0] LAST_REF = RW'(WIN_REFS - 1);

    logic [RW-1:0]    ref_cnt;
    logic [CNT_W-1:0] rec_cnt;
    logic [CNT_W-1:0] rec_next;
    logic             closing;

    // Next recovered count, holding at all-ones.
    always_comb begin
        rec_next = rec_cnt;
        if (rec_tick_i && (rec_cnt != '1)) rec_next = rec_cnt + 1'b1;
    end

    // The reference strobe that completes the window.
    assign closing = ref_tick_i && (ref_cnt == LAST_REF);

    // Window and event counters, result latch and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else if (restart_i) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
            done_o  <= 1'b0;
        end else if (closing) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
            done_o  <= 1'b1;
            count_o <= rec_next;
        end else begin
            if (ref_tick_i) ref_cnt <= ref_cnt + 1'b1;
            rec_cnt <= rec_next;
            done_o  <= 1'b0;
        end
    end

    // R2: the reference counter never leaves the window range.
    a_r2_ref_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= LAST_REF);

    // R2: a window close yields a single-cycle done strobe.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    initial begin
        a_r2_win_min: assert (WIN_REFS >= 2);
    end

endmodule

// File: rtl/fld_judge.sv
// Module: fld_judge
// Turns a finished window count into a lock decision. Holds per-select tables
// of the nominal count and both ppm limits, forms |count - nominal| and applies
// hysteresis: acquire at or below the tight limit, lose above the wide one.
// Assumes LOCK_PPM <= LOSE_PPM and RATIO_00 >= 8 so every select has a count.
module fld_judge
    import fld_pkg::*;
#(
    parameter int unsigned WIN_REFS = 1024,
    parameter int unsigned RATIO_00 = 128,
    parameter int unsigned LOCK_PPM = 500,
    parameter int unsigned LOSE_PPM = 1000,
    parameter int unsigned CNT_W    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [1:0]       sel_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             lol_o,
    output logic             valid_o
);
    localparam int unsigned NSEL = 4;

    logic [CNT_W-1:0] nom_tab  [NSEL];
    logic [CNT_W-1:0] lock_tab [NSEL];
    logic [CNT_W-1:0] lose_tab [NSEL];

    // One constant table row per reference select.
    for (genvar g = 0; g < NSEL; g++) begin : g_tab
        localparam longint unsigned NOM = nominal_count(RATIO_00, WIN_REFS, g);
        assign nom_tab[g]  = CNT_W'(NOM);
        assign lock_tab[g] = CNT_W'(ppm_limit(NOM, LOCK_PPM));
        assign lose_tab[g] = CNT_W'(ppm_limit(NOM, LOSE_PPM));
    end

    logic [CNT_W-1:0] nom;
    logic [CNT_W-1:0] err;
    logic             in_lock_band;
    logic             out_of_band;

    // Absolute error against the selected nominal count.
    always_comb begin
        nom = nom_tab[sel_i];
        err = (count_i >= nom) ? (count_i - nom) : (nom - count_i);
        in_lock_band = (err <= lock_tab[sel_i]);
        out_of_band  = (err >  lose_tab[sel_i]);
    end

    // Hysteretic lock flag and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol_o   <= 1'b1;
            valid_o <= 1'b0;
        end else if (restart_i) begin
            lol_o   <= 1'b1;
            valid_o <= 1'b0;
        end else begin
            valid_o <= done_i;
            if (done_i) begin
                if (lol_o && in_lock_band)      lol_o <= 1'b0;
                else if (!lol_o && out_of_band) lol_o <= 1'b1;
            end
        end
    end

    // R4: a close inside the tight band acquires lock.
    a_r4_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !restart_i && lol_o && in_lock_band) |=> !lol_o);

    // R5: a close outside the wide band drops lock.
    a_r5_lose: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !restart_i && !lol_o && out_of_band) |=> lol_o);

    // R6: with no close and no restart the flag holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !restart_i) |=> $stable(lol_o));

    // R6: a close in the hysteresis band keeps the flag.
    a_r6_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !restart_i && !in_lock_band && !out_of_band) |=> $stable(lol_o));

    initial begin
        a_r3_ratio_min: assert (RATIO_00 >= 8);
        a_r6_ppm_order: assert (LOCK_PPM <= LOSE_PPM);
    end

endmodule

// File: rtl/freq_lock_monitor.sv
// Module: freq_lock_monitor (top)
// Frequency lock detector with hysteresis. Registers the reference select,
// restarts measurement when it changes, and ties a gate counter to a
// threshold judge. Drives loss-of-lock and the frequency/phase loop select.
// Assumes both clock inputs are already single-cycle strobes in clk's domain.
module freq_lock_monitor
    import fld_pkg::*;
#(
    parameter int unsigned WIN_REFS = 1024,
    parameter int unsigned RATIO_00 = 128,
    parameter int unsigned LOCK_PPM = 500,
    parameter int unsigned LOSE_PPM = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic       rec_tick_i,
    input  logic [1:0] ref_sel_i,
    output logic       lol_o,
    output logic       freq_loop_o,
    output logic       meas_valid_o
);
    localparam int unsigned CNT_W = $clog2(RATIO_00 * WIN_REFS) + 2;

    logic [1:0]       sel_q;
    logic             sel_chg;
    logic             gate_done;
    logic [CNT_W-1:0] gate_count;
    loop_sel_e        loop_sel;

    assign sel_chg = (ref_sel_i != sel_q);

    // Track the select in use so a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 2'b00;
        else        sel_q <= ref_sel_i;
    end

    fld_gate #(
        .WIN_REFS (WIN_REFS),
        .CNT_W    (CNT_W)
    ) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (sel_chg),
        .ref_tick_i (ref_tick_i),
        .rec_tick_i (rec_tick_i),
        .done_o     (gate_done),
        .count_o    (gate_count)
    );

    fld_judge #(
        .WIN_REFS (WIN_REFS),
        .RATIO_00 (RATIO_00),
        .LOCK_PPM (LOCK_PPM),
        .LOSE_PPM (LOSE_PPM),
        .CNT_W    (CNT_W)
    ) judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (sel_chg),
        .sel_i     (sel_q),
        .done_i    (gate_done),
        .count_i   (gate_count),
        .lol_o     (lol_o),
        .valid_o   (meas_valid_o)
    );

    // Loop select follows the lock flag.
    assign loop_sel    = lol_o ? LOOP_FREQ : LOOP_PHASE;
    assign freq_loop_o = (loop_sel == LOOP_FREQ);

    // R8: a select change forces loss-of-lock and suppresses the result strobe.
    a_r8_sel_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (lol_o && !meas_valid_o));

    // R2: a result strobe is always preceded by a gate close.
    a_r2_valid_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> $past(gate_done));

endmodule

// File: tb/freq_lock_monitor_tb_top.sv
// Directed bench for freq_lock_monitor with a reduced window for run time.
// Nominal counts with WIN=256, RATIO_00=32: 8192 / 4096 / 2048 / 1024;
// limits (lock, lose): 00 -> (4,8), 10 -> (1,2), 11 -> (0,1).
module freq_lock_monitor_tb_top;
    localparam int unsigned WIN = 256;
    localparam int unsigned R0  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rec_tick = 1'b0;
    logic [1:0] ref_sel = 2'b00;
    logic       lol, freq_loop, meas_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    freq_lock_monitor #(.WIN_REFS(WIN), .RATIO_00(R0)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick_i   (ref_tick),
        .rec_tick_i   (rec_tick),
        .ref_sel_i    (ref_sel),
        .lol_o        (lol),
        .freq_loop_o  (freq_loop),
        .meas_valid_o (meas_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nominal(input logic [1:0] s);
        return (R0 >> s) * WIN;
    endfunction

    // One full window with n_rec recovered strobes; checks strobe timing and flag.
    task automatic run_window(input int n_rec, input bit exp_lol, input string req);
        int rp = (R0 >> ref_sel) + 1;
        int len = WIN * rp;
        int early = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (meas_valid) early++;
            ref_tick = ((i % rp) == rp - 1);
            rec_tick = (i < n_rec);
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        chk(early == 0 && meas_valid == 1'b0, "R2 no strobe before close+1", early + meas_valid, 0);
        @(negedge clk);
        chk(meas_valid == 1'b1, "R2 strobe one cycle after close", meas_valid, 1);
        chk(lol == exp_lol, req, lol, exp_lol);
        chk(freq_loop == lol, "R7 loop select follows flag", freq_loop, lol);
        @(negedge clk);
        chk(meas_valid == 1'b0, "R2 strobe lasts one cycle", meas_valid, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lol == 1'b1, "R1 lol after reset", lol, 1);
        chk(freq_loop == 1'b1, "R1 R7 frequency loop after reset", freq_loop, 1);
        chk(meas_valid == 1'b0, "R1 no strobe after reset", meas_valid, 0);
    endtask

    // Acquire, band hold, boundary, lose, band hold while unlocked, reacquire.
    task automatic t_hysteresis;
        int e = nominal(2'b00);
        run_window(e + 4, 1'b0, "R4 acquire at tight limit (+4)");
        run_window(e - 7, 1'b0, "R6 band error -7 keeps lock");
        run_window(e + 8, 1'b0, "R5 error equal to wide limit keeps lock");
        run_window(e + 9, 1'b1, "R5 error above wide limit drops lock");
        run_window(e + 5, 1'b1, "R6 R4 error just above tight limit stays unlocked");
        run_window(e - 4, 1'b0, "R4 reacquire at -4");
    endtask

    task automatic change_sel(input logic [1:0] s);
        @(negedge clk);
        ref_sel = s;
        @(negedge clk);
        chk(lol == 1'b1, "R8 select change forces lol", lol, 1);
        chk(meas_valid == 1'b0, "R8 no strobe on select change", meas_valid, 0);
    endtask

    // Select scaling and discarded partial window.
    task automatic t_select;
        int early = 0;
        change_sel(2'b11);
        run_window(nominal(2'b11), 1'b0, "R3 code 11 nominal 1024 locks");
        run_window(nominal(2'b11) + 2, 1'b1, "R3 R5 code 11 error 2 drops lock");
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (meas_valid) early++;
            ref_tick = ((i % 5) == 4);
            rec_tick = 1'b1;
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        change_sel(2'b10);
        chk(early == 0, "R8 partial window gives no strobe", early, 0);
        run_window(nominal(2'b10), 1'b0, "R8 R3 fresh window after restart locks at 2048");
    endtask

    initial begin
        t_reset();
        t_hysteresis();
        t_select();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule